// File: doc/BRIEF.md
# DMA Channel Address and Count Engine

This block is the datapath of one DMA channel. Software loads a page value, a 16-bit start address, a 16-bit count holding one less than the number of transfers, and a mode made of transfer direction, auto-initialise and byte or word width. Each cycle in which the bus arbiter grants the channel and the channel is unmasked is one transfer. In that cycle the engine drives a 24-bit physical address and then steps its address up and its count down.

Physical addresses are formed in one of two ways. A byte channel places the page above a 16-bit byte address. A word channel places the upper seven page bits above a 16-bit word address shifted left by one, so bit 0 is always zero. The page never takes a carry, so a transfer wraps inside a 64K window (byte) or a 128K window (word). Terminal count is flagged on the transfer that takes the count from zero to all ones. After it, a single-shot channel masks itself and an auto-initialise channel reloads its start values. The current count is always visible so software can read the residue.

Top module: `dma_chan_engine`

## Requirements
- R1: After reset `masked` is 1, `cur_count` is 0, `phys_addr` is 0, `tc` is 0 and `to_mem` is 0.
- R2: A cycle with `ld` high stores page, address, count and the three mode bits as both base and current values. It performs no transfer that cycle, and the new count is visible on `cur_count` from the next cycle.
- R3: With width bit `ld_word`=0 (byte), `phys_addr[23:16]` is the page and `phys_addr[15:0]` is the current address.
- R4: With `ld_word`=1 (word), `phys_addr[23:17]` is page bits 7..1, `phys_addr[16:1]` is the current address and `phys_addr[0]` is 0. Page bit 0 has no effect on the address.
- R5: A transfer cycle (`grant`=1, `masked`=0, `ld`=0) adds one to the current address and subtracts one from the current count.
- R6: The address wraps from 0xFFFF to 0x0000 with no carry into the page, so the upper physical bits stay fixed.
- R7: `tc` is 1 exactly in a transfer cycle whose current count is 0x0000. On a single-shot channel the count then reads 0xFFFF.
- R8: On a single-shot channel (`ld_auto`=0) terminal count sets `masked`, and later grants leave address and count unchanged.
- R9: On an auto-initialise channel (`ld_auto`=1) terminal count reloads the base address and count and leaves the channel unmasked.
- R10: While `grant` is 0 or `masked` is 1, address and count hold.
- R11: `mask_set` sets `masked` and `mask_clr` clears it. When both are high, set wins.
- R12: A loaded count of N-1 gives exactly N transfers before terminal count, including 0xFFFF giving 65536.
- R13: `to_mem` shows the direction bit stored by the last load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld | input | 1 | Load strobe for all configuration fields |
| ld_page | input | 8 | Page value |
| ld_addr | input | 16 | Start address (bytes or words) |
| ld_count | input | 16 | Transfer count minus one |
| ld_word | input | 1 | 1 = word channel, 0 = byte channel |
| ld_auto | input | 1 | 1 = reload at terminal count |
| ld_to_mem | input | 1 | Direction bit, 1 = device to memory |
| mask_set | input | 1 | Set channel mask |
| mask_clr | input | 1 | Clear channel mask |
| grant | input | 1 | Bus cycle granted to this channel |
| phys_addr | output | 24 | Physical address of the current transfer |
| tc | output | 1 | Terminal count, valid in the transfer cycle |
| cur_count | output | 16 | Current count (residue minus one) |
| masked | output | 1 | Channel mask state |
| to_mem | output | 1 | Stored direction |

## Verification
The bench builds the engine with its default 8-bit page and 16-bit counter. With those widths a full 65536-transfer run fits in the cycle budget, so the largest count and the wrap of the count to all ones on a complete transfer are both reached. Start addresses of 0xFFFE and 0xFFFF bring the address wrap inside the page window within a few cycles, in both byte and word widths. Odd page values show that page bit 0 is dropped on word channels.

// File: rtl/dma_chan_engine.sv
module dma_chan_engine #(
  parameter int CNT_W  = 16,
  parameter int PAGE_W = 8,
  localparam int PHYS_W = PAGE_W + CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic [PAGE_W-1:0] ld_page,
  input  logic [CNT_W-1:0]  ld_addr,
  input  logic [CNT_W-1:0]  ld_count,
  input  logic              ld_word,
  input  logic              ld_auto,
  input  logic              ld_to_mem,
  input  logic              mask_set,
  input  logic              mask_clr,
  input  logic              grant,
  output logic [PHYS_W-1:0] phys_addr,
  output logic              tc,
  output logic [CNT_W-1:0]  cur_count,
  output logic              masked,
  output logic              to_mem
);

  logic [PAGE_W-1:0] page_q;
  logic [CNT_W-1:0]  base_addr_q, base_cnt_q, addr_q, cnt_q;
  logic              word_q, auto_q, dir_q, mask_q;
  logic              xfer;

  assign xfer      = grant && !mask_q && !ld;
  assign tc        = xfer && (cnt_q == '0);
  assign cur_count = cnt_q;
  assign masked    = mask_q;
  assign to_mem    = dir_q;
  assign phys_addr = word_q ? {page_q[PAGE_W-1:1], addr_q, 1'b0}
                            : {page_q, addr_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_q      <= '0;
      base_addr_q <= '0;
      base_cnt_q  <= '0;
      addr_q      <= '0;
      cnt_q       <= '0;
      word_q      <= 1'b0;
      auto_q      <= 1'b0;
      dir_q       <= 1'b0;
    end else if (ld) begin
      page_q      <= ld_page;
      base_addr_q <= ld_addr;
      base_cnt_q  <= ld_count;
      addr_q      <= ld_addr;
      cnt_q       <= ld_count;
      word_q      <= ld_word;
      auto_q      <= ld_auto;
      dir_q       <= ld_to_mem;
    end else if (xfer) begin
      if (tc && auto_q) begin
        addr_q <= base_addr_q;
        cnt_q  <= base_cnt_q;
      end else begin
        addr_q <= addr_q + 1'b1;
        cnt_q  <= cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                        mask_q <= 1'b1;
    else if (mask_set || (tc && !auto_q)) mask_q <= 1'b1;
    else if (mask_clr)                 mask_q <= 1'b0;
  end

endmodule

// File: rtl/dma_chan_engine_chk.sv
module dma_chan_engine_chk #(
  parameter int CNT_W  = 16,
  parameter int PAGE_W = 8,
  localparam int PHYS_W = PAGE_W + CNT_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ld,
  input logic              grant,
  input logic              mask_set,
  input logic              tc,
  input logic              masked,
  input logic [CNT_W-1:0]  cur_count,
  input logic [PHYS_W-1:0] phys_addr,
  input logic              auto_q,
  input logic              word_q
);

  assert_tc_in_xfer_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tc |-> (grant && !masked && !ld));

  assert_tc_wraps_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tc && !auto_q) |=> (cur_count == {CNT_W{1'b1}}));

  assert_tc_masks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tc && !auto_q) |=> masked);

  assert_autoinit_open_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tc && auto_q && !mask_set) |=> !masked);

  assert_word_even_R4: assert property (@(posedge clk) disable iff (!rst_n)
    word_q |-> (phys_addr[0] == 1'b0));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && (!grant || masked)) |=> ($stable(cur_count) && $stable(phys_addr)));

  assert_page_fixed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ld |=> $stable(phys_addr[PHYS_W-1:CNT_W+1]));

  assert_decrement_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && !masked && !ld && !tc) |=> (cur_count == CNT_W'($past(cur_count) - 1'b1)));

  assert_mask_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mask_set |=> masked);

endmodule

bind dma_chan_engine dma_chan_engine_chk #(.CNT_W(CNT_W), .PAGE_W(PAGE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .ld(ld), .grant(grant), .mask_set(mask_set),
  .tc(tc), .masked(masked), .cur_count(cur_count), .phys_addr(phys_addr),
  .auto_q(auto_q), .word_q(word_q)
);

// File: tb/dma_chan_engine_tb_top.sv
`timescale 1ns/1ps
module dma_chan_engine_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld = 0, ld_word = 0, ld_auto = 0, ld_to_mem = 0;
  logic mask_set = 0, mask_clr = 0, grant = 0;
  logic [7:0]  ld_page = 0;
  logic [15:0] ld_addr = 0, ld_count = 0;
  logic [23:0] phys_addr;
  logic        tc, masked, to_mem;
  logic [15:0] cur_count;

  always #4 clk = ~clk;

  dma_chan_engine dut_i (
    .clk(clk), .rst_n(rst_n), .ld(ld), .ld_page(ld_page), .ld_addr(ld_addr),
    .ld_count(ld_count), .ld_word(ld_word), .ld_auto(ld_auto), .ld_to_mem(ld_to_mem),
    .mask_set(mask_set), .mask_clr(mask_clr), .grant(grant),
    .phys_addr(phys_addr), .tc(tc), .cur_count(cur_count), .masked(masked), .to_mem(to_mem)
  );

  int vectors = 0, errors = 0;
  string cur_req = "R1";
  bit done = 0;

  int m_page, m_baddr, m_bcnt, m_addr, m_cnt;
  bit m_word, m_auto, m_dir, m_mask;
  int tc_seen = 0;

  function automatic int exp_phys();
    if (m_word) return ((m_page / 2) * 131072) + (m_addr * 2);
    return (m_page * 65536) + m_addr;
  endfunction

  function automatic bit exp_tc();
    return grant && !m_mask && !ld && (m_cnt == 0);
  endfunction

  // behavioural reference, updated on each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_page = 0; m_baddr = 0; m_bcnt = 0; m_addr = 0; m_cnt = 0;
      m_word = 0; m_auto = 0; m_dir = 0; m_mask = 1;
    end else begin
      bit t;
      t = exp_tc();
      if (ld) begin
        m_page = ld_page; m_baddr = ld_addr; m_bcnt = ld_count;
        m_addr = ld_addr; m_cnt = ld_count;
        m_word = ld_word; m_auto = ld_auto; m_dir = ld_to_mem;
      end else if (grant && !m_mask) begin
        if (t && m_auto) begin m_addr = m_baddr; m_cnt = m_bcnt; end
        else begin m_addr = (m_addr + 1) % 65536; m_cnt = (m_cnt + 65535) % 65536; end
      end
      if (mask_set || (t && !m_auto)) m_mask = 1;
      else if (mask_clr) m_mask = 0;
    end
  end

  // compare away from the active edge
  always @(negedge clk) begin
    #2;
    if (!done) begin
      vectors++;
      if (phys_addr !== 24'(exp_phys()) || tc !== exp_tc() || cur_count !== 16'(m_cnt)
          || masked !== m_mask || to_mem !== m_dir) begin
        errors++;
        $display("FAIL %s: phys=%h tc=%b cnt=%h mask=%b dir=%b expected phys=%h tc=%b cnt=%h mask=%b dir=%b",
                 cur_req, phys_addr, tc, cur_count, masked, to_mem,
                 24'(exp_phys()), exp_tc(), 16'(m_cnt), m_mask, m_dir);
      end
      if (exp_tc()) tc_seen++;
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(input logic [7:0] p, input logic [15:0] a, input logic [15:0] c,
                      input bit w, input bit au, input bit d);
    ld = 1; ld_page = p; ld_addr = a; ld_count = c; ld_word = w; ld_auto = au; ld_to_mem = d;
    cyc(1);
    ld = 0;
  endtask

  task automatic unmask();
    mask_clr = 1; cyc(1); mask_clr = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    // R1: reset state
    cur_req = "R1";
    @(negedge clk); cyc(2);
    rst_n = 1; cyc(3);

    // R2 R3 R13: byte load, direction, transfers with gaps (R10)
    cur_req = "R2/R3/R13";
    load(8'h12, 16'h3400, 16'd4, 0, 0, 1);
    cyc(2);
    unmask();
    cur_req = "R5/R10";
    grant = 1; cyc(2); grant = 0; cyc(2); grant = 1;
    cur_req = "R7/R8/R12";
    cyc(6); grant = 0;
    if (tc_seen != 1) begin errors++; $display("FAIL R12: tc count actual=%0d expected=1", tc_seen); end
    vectors++;
    grant = 1; cyc(3); grant = 0;   // R8 grants ignored while masked

    // R4: word channel, odd page
    cur_req = "R4";
    load(8'h13, 16'h8001, 16'd2, 1, 0, 0);
    unmask(); grant = 1; cyc(4); grant = 0;

    // R6: wraps without page carry
    cur_req = "R6";
    load(8'hA5, 16'hFFFE, 16'd3, 0, 0, 1);
    unmask(); grant = 1; cyc(5); grant = 0;
    load(8'h7F, 16'hFFFF, 16'd2, 1, 0, 1);
    unmask(); grant = 1; cyc(4); grant = 0;

    // R9: auto-initialise reload
    cur_req = "R9";
    load(8'h02, 16'h0010, 16'd1, 0, 1, 0);
    unmask(); grant = 1; cyc(7);
    // load while granted: no transfer that cycle (R2)
    cur_req = "R2";
    load(8'h03, 16'h0100, 16'd5, 0, 1, 0);
    cyc(2); grant = 0;

    // R11: mask controls
    cur_req = "R11";
    mask_set = 1; mask_clr = 1; cyc(1); mask_set = 0; mask_clr = 0;
    grant = 1; cyc(2);
    unmask(); cyc(2);
    mask_set = 1; cyc(1); mask_set = 0; cyc(2); grant = 0;

    // R12: full 65536-transfer count
    cur_req = "R12";
    load(8'h40, 16'h0000, 16'hFFFF, 0, 0, 0);
    unmask();
    tc_seen = 0;
    grant = 1; cyc(65540); grant = 0;
    if (tc_seen != 1) begin errors++; $display("FAIL R12: tc count actual=%0d expected=1", tc_seen); end
    vectors++;
    cyc(2);
    finish_run();
  end
endmodule